// File: doc/BRIEF.md
# I2C Target with Word-Accessed Byte Files

This block is an I2C target that moves bus bytes through two circular 64-byte files. The bus controller writes bytes into the receive file. It reads bytes back from the transmit file. The local CPU reaches both files only as whole 32-bit words, through a single-cycle register port. A CPU write takes effect at the next clock edge. A CPU read returns data in the same cycle. The register port has no back-pressure and no wait states.

Two pointers track the byte streams, and both wrap around with no handshake. The receive pointer counts whole bytes accepted from the bus. The transmit pointer counts individual bits sent on the bus. Software works out how much new data has arrived by comparing the pointers with the values it saw last time. Three bus events raise sticky status bits, and each bit can be enabled onto one interrupt line.

The target only drives SDA. It drives SDA low to acknowledge and to send zero bits. SCL is an input, because the target never stretches the clock.

Top module: `i2c_wordbuf_target`

## Requirements
- R1: After reset:
  - the device address reads 0x50;
  - both pointers, the interrupt enable and the interrupt status read 0;
  - `sda_oe` is 0 and `irq` is 0.
- R2: The target pulls SDA low in the ninth clock after a START only when the 7 address bits match the device address register. For any other address it leaves SDA released until the next START.
- R3: During a write to this target, each complete data byte is acknowledged and stored at the receive pointer. Byte `p` lands in word `p[5:2]`, lane `p[1:0]`, and lane n occupies bits 8n+7:8n. The pointer then increments and wraps modulo 64.
- R4: A STOP or START in the middle of a data byte discards that partial byte. The receive pointer does not move and the file is not changed.
- R5: During a read, bits go out MSB first from transmit byte `tx_ptr[8:3]`. `tx_ptr` increments on every data bit sent and wraps modulo 512, so bits [2:0] give the bit position within the byte. An ACK from the controller continues the transfer. After a NACK, SDA stays released.
- R6: The interrupt status has three bits:
  - bit 0 is set when a read address is acknowledged;
  - bit 1 is set when a STOP or START ends a read transfer;
  - bit 2 is set when a STOP or START ends a write transfer addressed to this target.

  `irq` is the OR of (status AND enable).
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: Word addresses 0x00–0x0F read the receive file, and CPU writes there are ignored. Addresses 0x10–0x1F read and write the transmit file.
- R9: Writing the receive pointer (0x20, bits [5:0]) or the transmit pointer (0x21, bits [8:0]) loads that value. Writing zero rewinds the pointer.
- R10: Writing 1 to bit 0 of control register 0x25 returns the bus sequencer to idle and releases SDA on the next cycle. Both files keep their contents.
- R11: The device address at 0x24 (bits [6:0]) can be written. The target then answers only the new address. Interrupt enable is at 0x22 and status is at 0x23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| cpu_addr | input | 6 | CPU word address |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, combinational from `cpu_addr` |
| irq | output | 1 | Enabled interrupt request |

## Verification
The hardest case to reach from the ports is a soft reset issued while the target itself is holding SDA low in the middle of a read. The bench creates it in three steps:
- It loads a transmit byte whose MSB is zero.
- It addresses the target for a read and stops clocking just after the address acknowledge, at the point where the target starts driving the first data bit.
- It issues the soft reset, then confirms that SDA is released, that further clocks are ignored, and that both files still hold their data.

Address matching is swept over all 128 addresses. The byte files are checked across a pointer wrap in both directions.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_WDATA, S_WDATA_ACK, S_RDATA, S_RACK, S_HOLD
  } bus_st_e;

  localparam int EV_RD_START = 0;
  localparam int EV_RD_END   = 1;
  localparam int EV_WR_END   = 2;
  localparam int EV_N        = 3;

  // register slots, counted from the end of the two word windows
  localparam int REG_RXPTR = 0;
  localparam int REG_TXPTR = 1;
  localparam int REG_IEN   = 2;
  localparam int REG_ISTS  = 3;
  localparam int REG_DEV   = 4;
  localparam int REG_CTRL  = 5;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0][1:0] pipe;
  logic [1:0] prev;
  logic scl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '1;
      prev <= '1;
    end else begin
      pipe <= {pipe[STAGES-2:0], {scl_i, sda_i}};
      prev <= pipe[STAGES-1];
    end
  end

  assign scl       = pipe[STAGES-1][1];
  assign sda       = pipe[STAGES-1][0];
  assign scl_rise  = scl & ~prev[1];
  assign scl_fall  = ~scl & prev[1];
  assign start_det = scl & prev[1] & prev[0] & ~sda;
  assign stop_det  = scl & prev[1] & ~prev[0] & sda;
endmodule

// File: rtl/i2ct_bytefile.sv
module i2ct_bytefile #(
  parameter int BYTES = 64,
  parameter int PW    = $clog2(BYTES),
  parameter int WW    = $clog2(BYTES / 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               b_we,
  input  logic [PW-1:0]      b_idx,
  input  logic [7:0]         b_wd,
  input  logic               w_we,
  input  logic [WW-1:0]      w_idx,
  input  logic [31:0]        w_wd,
  output logic [8*BYTES-1:0] flat
);
  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= '0;
      else if (w_we && w_idx == WW'(i / 4))     q <= w_wd[8*(i%4) +: 8];
      else if (b_we && b_idx == PW'(i))         q <= b_wd;
    end
    assign flat[8*i +: 8] = q;
  end
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int PW = 6,
  parameter int TW = PW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [6:0]      dev_addr,
  input  logic            soft_rst,
  input  logic            rxp_ld,
  input  logic            txp_ld,
  input  logic [TW-1:0]   ld_val,
  input  logic [7:0]      tx_byte,
  output logic            sda_oe,
  output logic            rx_we,
  output logic [PW-1:0]   rx_ptr,
  output logic [7:0]      rx_byte,
  output logic [TW-1:0]   tx_ptr,
  output logic [EV_N-1:0] ev
);
  bus_st_e    st;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       is_rd, act_wr, act_rd;
  logic       cur_bit, bus_evt, tx_adv;

  assign cur_bit = tx_byte[~tx_ptr[2:0]];
  assign bus_evt = start_det | stop_det;
  assign tx_adv  = !soft_rst && !bus_evt && st == S_RDATA && scl_rise;
  assign rx_byte = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; cnt <= '0; is_rd <= 1'b0;
      act_wr <= 1'b0; act_rd <= 1'b0; sda_oe <= 1'b0;
      rx_we <= 1'b0; ev <= '0; rx_ptr <= '0; tx_ptr <= '0;
    end else begin
      ev    <= '0;
      rx_we <= 1'b0;
      if (soft_rst) begin
        st <= S_IDLE; sda_oe <= 1'b0; cnt <= '0;
        act_wr <= 1'b0; act_rd <= 1'b0;
      end else if (bus_evt) begin
        ev[EV_WR_END] <= act_wr;
        ev[EV_RD_END] <= act_rd;
        act_wr <= 1'b0; act_rd <= 1'b0;
        sda_oe <= 1'b0; cnt <= '0;
        st <= start_det ? S_ADDR : S_IDLE;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda}; cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (sh[7:1] == dev_addr) begin
                sda_oe <= 1'b1; is_rd <= sh[0];
                ev[EV_RD_START] <= sh[0];
                st <= S_ADDR_ACK;
              end else begin
                st <= S_HOLD;
              end
            end
          end
          S_ADDR_ACK: if (scl_fall) begin
            if (is_rd) begin
              st <= S_RDATA; sda_oe <= ~cur_bit; act_rd <= 1'b1;
            end else begin
              st <= S_WDATA; sda_oe <= 1'b0; act_wr <= 1'b1;
            end
          end
          S_WDATA: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda}; cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              rx_we <= 1'b1; sda_oe <= 1'b1; cnt <= '0;
              st <= S_WDATA_ACK;
            end
          end
          S_WDATA_ACK: if (scl_fall) begin
            sda_oe <= 1'b0; st <= S_WDATA;
          end
          S_RDATA: begin
            if (scl_fall) sda_oe <= ~cur_bit;
            else if (scl_rise && tx_ptr[2:0] == 3'd7) st <= S_RACK;
          end
          S_RACK: begin
            if (scl_fall) sda_oe <= 1'b0;
            else if (scl_rise) st <= sda ? S_HOLD : S_RDATA;
          end
          default: ;
        endcase
      end

      if (rxp_ld)     rx_ptr <= ld_val[PW-1:0];
      else if (rx_we) rx_ptr <= rx_ptr + 1'b1;
      if (txp_ld)      tx_ptr <= ld_val;
      else if (tx_adv) tx_ptr <= tx_ptr + 1'b1;
    end
  end

  // R10: a soft reset lets go of the data line at once
  a_r10_soft_release: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !sda_oe);
  // R3: the receive pointer only steps by one unless software loads it
  a_r3_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rxp_ld) && rx_ptr != $past(rx_ptr)) |-> rx_ptr == PW'($past(rx_ptr) + 1'b1));
  // R2: the line is pulled only in acknowledge or read-data phases
  a_r2_drive_phase: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == S_ADDR_ACK || st == S_WDATA_ACK || st == S_RDATA || st == S_RACK));
  // R5: a NACK from the controller leaves the line released
  a_r5_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK && scl_rise && sda && !soft_rst) |=> !sda_oe);
endmodule

// File: rtl/i2c_wordbuf_target.sv
module i2c_wordbuf_target
  import i2ct_pkg::*;
#(
  parameter int         FILE_BYTES  = 64,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_RESET  = 7'h50,
  parameter int         PW          = $clog2(FILE_BYTES),
  parameter int         WW          = PW - 2,
  parameter int         AW          = WW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_we,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  output logic          irq
);
  localparam int TW       = PW + 3;
  localparam int REG_BASE = 2 * (FILE_BYTES / 4);

  logic sda, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0]            dev_addr;
  logic [EV_N-1:0]       ien, sts, ev, w1c;
  logic                  rx_we, soft_rst, rxp_ld, txp_ld, tx_wwe;
  logic [PW-1:0]         rx_ptr;
  logic [TW-1:0]         tx_ptr;
  logic [7:0]            rx_byte, tx_byte;
  logic [8*FILE_BYTES-1:0] rx_flat, tx_flat;
  logic [WW-1:0]         widx;

  function automatic logic hit(input logic [AW-1:0] a, input int k);
    return a == AW'(REG_BASE + k);
  endfunction

  assign widx     = cpu_addr[WW-1:0];
  assign soft_rst = cpu_we && hit(cpu_addr, REG_CTRL) && cpu_wdata[0];
  assign rxp_ld   = cpu_we && hit(cpu_addr, REG_RXPTR);
  assign txp_ld   = cpu_we && hit(cpu_addr, REG_TXPTR);
  assign tx_wwe   = cpu_we && cpu_addr[AW-1:AW-2] == 2'b01;
  assign w1c      = (cpu_we && hit(cpu_addr, REG_ISTS)) ? cpu_wdata[EV_N-1:0] : '0;
  assign tx_byte  = tx_flat[{tx_ptr[TW-1:3], 3'd0} +: 8];
  assign irq      = |(sts & ien);

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda(sda),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2ct_engine #(.PW(PW), .TW(TW)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda(sda), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .dev_addr(dev_addr), .soft_rst(soft_rst),
    .rxp_ld(rxp_ld), .txp_ld(txp_ld), .ld_val(cpu_wdata[TW-1:0]), .tx_byte(tx_byte),
    .sda_oe(sda_oe), .rx_we(rx_we), .rx_ptr(rx_ptr), .rx_byte(rx_byte),
    .tx_ptr(tx_ptr), .ev(ev)
  );

  i2ct_bytefile #(.BYTES(FILE_BYTES), .PW(PW), .WW(WW)) u_rxfile (
    .clk(clk), .rst_n(rst_n), .b_we(rx_we), .b_idx(rx_ptr), .b_wd(rx_byte),
    .w_we(1'b0), .w_idx(widx), .w_wd(32'd0), .flat(rx_flat)
  );

  i2ct_bytefile #(.BYTES(FILE_BYTES), .PW(PW), .WW(WW)) u_txfile (
    .clk(clk), .rst_n(rst_n), .b_we(1'b0), .b_idx(rx_ptr), .b_wd(8'd0),
    .w_we(tx_wwe), .w_idx(widx), .w_wd(cpu_wdata), .flat(tx_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_addr <= ADDR_RESET;
      ien      <= '0;
      sts      <= '0;
    end else begin
      if (cpu_we && hit(cpu_addr, REG_DEV)) dev_addr <= cpu_wdata[6:0];
      if (cpu_we && hit(cpu_addr, REG_IEN)) ien <= cpu_wdata[EV_N-1:0];
      sts <= (sts & ~w1c) | ev;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (!cpu_addr[AW-1]) begin
      cpu_rdata = cpu_addr[AW-2] ? tx_flat[{widx, 5'd0} +: 32] : rx_flat[{widx, 5'd0} +: 32];
    end else if (hit(cpu_addr, REG_RXPTR)) cpu_rdata[PW-1:0]   = rx_ptr;
    else if (hit(cpu_addr, REG_TXPTR))     cpu_rdata[TW-1:0]   = tx_ptr;
    else if (hit(cpu_addr, REG_IEN))       cpu_rdata[EV_N-1:0] = ien;
    else if (hit(cpu_addr, REG_ISTS))      cpu_rdata[EV_N-1:0] = sts;
    else if (hit(cpu_addr, REG_DEV))       cpu_rdata[6:0]      = dev_addr;
  end

  // R6: the write-end status bit only rises from a sequencer event
  a_r6_wr_end_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[EV_WR_END]) |-> $past(ev[EV_WR_END]));
  // R7: writing one clears the bit when no new event coincides
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c[EV_RD_START] && !ev[EV_RD_START]) |=> !sts[EV_RD_START]);
endmodule

// File: tb/test_i2c_wordbuf_target.sv
module test_i2c_wordbuf_target;
  localparam logic [5:0] A_RXPTR = 6'h20, A_TXPTR = 6'h21, A_IEN = 6'h22,
                         A_STS = 6'h23, A_DEV = 6'h24, A_CTRL = 6'h25;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, irq, cpu_we = 1'b0;
  logic [5:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  wire line = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0, rptr = 0;
  bit done = 1'b0;
  logic [7:0] rxm [64];
  logic [7:0] txm [64];

  i2c_wordbuf_target i_i2c_wordbuf_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line), .sda_oe(sda_oe),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hp(); repeat (8) @(negedge clk); endtask

  task automatic cpu_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); cpu_addr = a; cpu_we = 1'b1; cpu_wdata = d;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); cpu_addr = a; #1 d = cpu_rdata;
  endtask

  task automatic bstart();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic bstop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic bbit(input logic b, output logic s);
    sda_m = b; hp(); scl_m = 1'b1; hp(); s = line; scl_m = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bbit(b[i], s);
    bbit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 0; i < 8; i++) begin
      bbit(1'b1, s);
      b = {b[6:0], s};
    end
    bbit(~give_ack, s);
  endtask

  function automatic logic [31:0] mword(input bit tx, input int w);
    if (tx) return {txm[4*w+3], txm[4*w+2], txm[4*w+1], txm[4*w]};
    return {rxm[4*w+3], rxm[4*w+2], rxm[4*w+1], rxm[4*w]};
  endfunction

  task automatic wr_xfer(input logic [6:0] a, input int n, input int seed,
                         input logic exp_ack, input string tag);
    logic ack;
    logic [7:0] d;
    bstart();
    wbyte({a, 1'b0}, ack);
    chk(tag, ack, exp_ack);
    if (ack) begin
      for (int i = 0; i < n; i++) begin
        d = 8'(seed + i * 37);
        wbyte(d, ack);
        chk("R3 data ack", ack, 1);
        rxm[rptr] = d;
        rptr = (rptr + 1) % 64;
      end
    end
    bstop();
  endtask

  task automatic tx_word(input int w, input logic [31:0] v);
    cpu_wr(6'(16 + w), v);
    for (int k = 0; k < 4; k++) txm[4*w+k] = v[8*k +: 8];
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] b;
    logic ack, s;
    for (int i = 0; i < 64; i++) begin rxm[i] = 8'h00; txm[i] = 8'h00; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cpu_rd(A_DEV, d);   chk("R1 dev addr", d, 32'h50);
    cpu_rd(A_RXPTR, d); chk("R1 rx ptr", d, 0);
    cpu_rd(A_TXPTR, d); chk("R1 tx ptr", d, 0);
    cpu_rd(A_STS, d);   chk("R1 status", d, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 irq", irq, 0);

    // R2 sweep every address with the write bit
    for (int a = 0; a < 128; a++) begin
      bstart();
      wbyte({7'(a), 1'b0}, ack);
      chk("R2 address ack", ack, (a == 'h50));
      bstop();
    end
    cpu_rd(A_STS, d); chk("R6 write end after sweep", d, 32'h4);
    cpu_wr(A_STS, 32'h7);

    // R3 long write wraps the receive file
    wr_xfer(7'h50, 70, 11, 1'b1, "R3 address ack");
    for (int w = 0; w < 16; w++) begin
      cpu_rd(6'(w), d); chk("R3 rx word", d, mword(0, w));
    end
    cpu_rd(A_RXPTR, d); chk("R3 rx ptr wrap", d, 32'(rptr));

    // R6 status and enable
    cpu_rd(A_STS, d); chk("R6 status", d, 32'h4);
    chk("R6 irq masked", irq, 0);
    cpu_wr(A_IEN, 32'h4);
    chk("R6 irq enabled", irq, 1);
    cpu_wr(A_STS, 32'h4);
    chk("R7 irq after clear", irq, 0);

    // R4 partial byte is discarded
    bstart();
    wbyte({7'h50, 1'b0}, ack);
    bbit(1'b1, s); bbit(1'b0, s); bbit(1'b1, s);
    bstop();
    cpu_rd(A_RXPTR, d); chk("R4 rx ptr held", d, 32'(rptr));
    cpu_rd(6'(rptr / 4), d); chk("R4 rx word kept", d, mword(0, rptr / 4));

    // R8 word access rules
    cpu_wr(6'h00, 32'hDEADBEEF);
    cpu_rd(6'h00, d); chk("R8 rx word read-only", d, mword(0, 0));
    for (int w = 0; w < 16; w++) tx_word(w, 32'h8C00_0000 ^ (32'(w) * 32'h0103_0507));
    for (int w = 0; w < 16; w++) begin
      cpu_rd(6'(16 + w), d); chk("R8 tx word", d, mword(1, w));
    end

    // R9 rewind the receive pointer
    cpu_wr(A_RXPTR, 0);
    cpu_rd(A_RXPTR, d); chk("R9 rx ptr rewind", d, 0);
    rptr = 0;
    wr_xfer(7'h50, 2, 200, 1'b1, "R9 address ack");
    cpu_rd(6'h00, d); chk("R9 lanes after rewind", d, mword(0, 0));
    cpu_wr(A_STS, 32'h7);

    // R5 read five bytes, last one NACKed
    cpu_wr(A_TXPTR, 0);
    bstart();
    wbyte({7'h50, 1'b1}, ack);
    chk("R5 read address ack", ack, 1);
    for (int i = 0; i < 5; i++) begin
      rbyte(i < 4, b);
      chk("R5 read byte", b, txm[i]);
    end
    bbit(1'b1, s);
    chk("R5 released after NACK", s, 1);
    bstop();
    cpu_rd(A_TXPTR, d); chk("R5 tx bit ptr", d, 40);
    cpu_rd(A_STS, d);   chk("R6 read start and end", d, 32'h3);
    cpu_wr(A_STS, 32'h1);
    cpu_rd(A_STS, d);   chk("R7 partial clear", d, 32'h2);
    cpu_wr(A_STS, 32'h2);
    cpu_rd(A_STS, d);   chk("R7 full clear", d, 0);

    // R5 read across the file wrap
    cpu_wr(A_TXPTR, 480);
    cpu_rd(A_TXPTR, d); chk("R9 tx ptr load", d, 480);
    bstart();
    wbyte({7'h50, 1'b1}, ack);
    for (int i = 0; i < 8; i++) begin
      rbyte(i < 7, b);
      chk("R5 wrap byte", b, txm[(60 + i) % 64]);
    end
    bstop();
    cpu_rd(A_TXPTR, d); chk("R5 tx ptr wrap", d, 32);

    // R10 soft reset while the target pulls SDA low
    tx_word(0, 32'h5A3C_1E00);
    cpu_wr(A_TXPTR, 0);
    bstart();
    wbyte({7'h50, 1'b1}, ack);
    repeat (6) @(negedge clk);
    chk("R5 drives zero bit", sda_oe, 1);
    cpu_wr(A_CTRL, 32'h1);
    chk("R10 sda released", sda_oe, 0);
    bbit(1'b1, s);
    chk("R10 idle after reset", s, 1);
    bstop();
    cpu_rd(6'h10, d); chk("R10 tx file kept", d, 32'h5A3C_1E00);
    cpu_rd(6'h00, d); chk("R10 rx file kept", d, mword(0, 0));
    wr_xfer(7'h50, 1, 77, 1'b1, "R10 works after reset");
    cpu_rd(A_RXPTR, d); chk("R10 rx ptr after reset", d, 32'(rptr));

    // R11 new device address
    cpu_wr(A_DEV, 32'h2A);
    cpu_rd(A_DEV, d); chk("R11 dev addr readback", d, 32'h2A);
    wr_xfer(7'h50, 1, 0, 1'b0, "R11 old address ignored");
    wr_xfer(7'h2A, 1, 91, 1'b1, "R11 new address ack");
    cpu_rd(6'(((rptr + 63) % 64) / 4), d);
    chk("R11 data stored", d, mword(0, ((rptr + 63) % 64) / 4));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule